// File: doc/BRIEF.md
# Change-of-State Interrupt Generator

This block watches a vector of status bits that arrive from other logic without a common clock. When any bit changes, rising or falling, the block records the change in a per-bit pending flag. It then pulls an active-low interrupt line for the host. Each bit has its own enable. A disabled bit still records its change, but it cannot pull the interrupt line.

The host reads the pending flags through a one-cycle read strobe. The read returns the flags as they stood on that clock edge and clears them in the same step. The interrupt is released once no enabled flag remains. A change that lands on the same edge as the read is kept for the next read.

The interrupt pin is modelled as an open-drain driver. One output enables the pull-down. A second output gives the level the line takes with an external pull-up. The line is never actively driven high.

Top module: `cos_irq_top`

## Requirements
- R1: After reset all pending flags and all enables are zero, `irq_oe_o` is 0, `irq_n_o` is 1 and `rd_valid_o` is 0.
- R2: A 0-to-1 change on an enabled `stat_i` bit, applied between clock edges, drives `irq_n_o` low on the fourth rising edge after the change and not before.
- R3: A 1-to-0 change on an enabled bit produces the same interrupt with the same latency as R2.
- R4: A change on a disabled bit sets its pending flag, which a later read shows, but `irq_n_o` stays high.
- R5: Writing an enable word (`mask_wr_i`=1, value on `mask_i`) loads it on that edge. If a pending flag is newly enabled, `irq_n_o` goes low on the following edge.
- R6: A read strobe (`rd_req_i`=1 for one edge) gives `rd_valid_o`=1 for exactly one cycle, with `rd_data_o` bit i equal to pending flag i before the edge. The flags clear on that edge, and `irq_n_o` returns high one edge later.
- R7: A change whose flag would be set on the same edge as a read is missing from that read's data and present in the next read.
- R8: `irq_n_o` is always the inverse of `irq_oe_o`. The line is low only while the pull-down is enabled.
- R9: Input levels that are static across reset produce no pending flag. Detection starts SYNC_STAGES+1 edges after reset is released.
- R10: Flags are sticky. A bit that changes and then changes back stays flagged until it is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stat_i | input | WIDTH | Asynchronous status bits to monitor |
| mask_wr_i | input | 1 | Load strobe for the enable word |
| mask_i | input | WIDTH | Enable word; bit i = 1 lets bit i raise the interrupt |
| rd_req_i | input | 1 | Read strobe for the pending-flag word |
| rd_data_o | output | WIDTH | Pending flags captured by the last read |
| rd_valid_o | output | 1 | One-cycle pulse marking new read data |
| irq_oe_o | output | 1 | Pull-down enable of the open-drain interrupt |
| irq_n_o | output | 1 | Interrupt line level, active low |

## Verification
The assertions check four things on every cycle:
- every detected edge, in either direction, lands in its flag;
- flags never drop except on a read;
- a read keeps exactly the changes arriving with it;
- an enabled pending flag pulls the line on the next edge, and no enabled pending flag releases it.

Only the bench scenarios can show the exact latency from an asynchronous input change through the synchronizer, and the absence of false flags after reset. They also cover a bit that is later enabled, and a change that collides with a read on the same edge.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int COS_DEF_WIDTH = 8;
  localparam int COS_DEF_SYNC  = 2;

  typedef enum logic {
    ARM_WAIT = 1'b0,
    ARM_LIVE = 1'b1
  } arm_state_e;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int WIDTH  = cos_pkg::COS_DEF_WIDTH,
  parameter int STAGES = cos_pkg::COS_DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/cos_change_latch.sv
module cos_change_latch #(
  parameter int WIDTH      = cos_pkg::COS_DEF_WIDTH,
  parameter int ARM_CYCLES = cos_pkg::COS_DEF_SYNC + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sync_i,
  input  logic             rd_clr_i,
  output logic [WIDTH-1:0] change_o,
  output logic [WIDTH-1:0] flags_o
);
  import cos_pkg::*;

  localparam int CW = $clog2(ARM_CYCLES + 1);
  localparam logic [CW-1:0] ARM_LAST = CW'(ARM_CYCLES - 1);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] flags_q;
  logic [CW-1:0]    arm_cnt_q;
  arm_state_e       arm_q;

  // Hold off detection until the synchronizer and previous-value
  // register have both absorbed the post-reset input levels.
  always_ff @(posedge clk) begin
    if (rst) begin
      arm_cnt_q <= '0;
      arm_q     <= ARM_WAIT;
    end else if (arm_q == ARM_WAIT) begin
      arm_cnt_q <= arm_cnt_q + 1'b1;
      if (arm_cnt_q == ARM_LAST) arm_q <= ARM_LIVE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_i;
  end

  assign change_o = (arm_q == ARM_LIVE) ? (sync_i ^ prev_q) : '0;

  always_ff @(posedge clk) begin
    if (rst)           flags_q <= '0;
    else if (rd_clr_i) flags_q <= change_o;
    else               flags_q <= flags_q | change_o;
  end

  assign flags_o = flags_q;

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
    !rd_clr_i |=> (($past(flags_q) & ~flags_q) == '0));            // R10
  AST_READ_KEEPS_NEW: assert property (@(posedge clk) disable iff (rst)
    rd_clr_i |=> (flags_q == $past(change_o)));                    // R7
  AST_NO_FLAG_WHILE_ARMING: assert property (@(posedge clk) disable iff (rst)
    (arm_q == ARM_WAIT && !$past(rst) && $past(flags_q) == '0) |-> (flags_q == '0)); // R9
endmodule

// File: rtl/cos_irq_drive.sv
module cos_irq_drive #(
  parameter int WIDTH = cos_pkg::COS_DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] flags_i,
  input  logic             mask_wr_i,
  input  logic [WIDTH-1:0] mask_i,
  output logic [WIDTH-1:0] mask_o,
  output logic             irq_oe_o
);
  logic [WIDTH-1:0] mask_q;
  logic             oe_q;
  logic [WIDTH-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst)            mask_q <= '0;
    else if (mask_wr_i) mask_q <= mask_i;
  end

  assign hit = flags_i & mask_q;

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= |hit;
  end

  assign mask_o   = mask_q;
  assign irq_oe_o = oe_q;

  AST_MASK_LOADED: assert property (@(posedge clk) disable iff (rst)
    mask_wr_i |=> (mask_q == $past(mask_i)));                      // R5
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !mask_wr_i |=> $stable(mask_q));                               // R5
endmodule

// File: rtl/cos_irq_top.sv
module cos_irq_top #(
  parameter int WIDTH       = cos_pkg::COS_DEF_WIDTH,
  parameter int SYNC_STAGES = cos_pkg::COS_DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] stat_i,
  input  logic             mask_wr_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic             rd_req_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             rd_valid_o,
  output logic             irq_oe_o,
  output logic             irq_n_o
);
  localparam int ARM_CYCLES = SYNC_STAGES + 1;

  logic [WIDTH-1:0] sync_w;
  logic [WIDTH-1:0] change_w;
  logic [WIDTH-1:0] flags_w;
  logic [WIDTH-1:0] mask_w;
  logic             oe_w;
  logic [WIDTH-1:0] rd_data_q;
  logic             rd_valid_q;

  cos_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (stat_i),
    .sync_o  (sync_w)
  );

  cos_change_latch #(.WIDTH(WIDTH), .ARM_CYCLES(ARM_CYCLES)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .sync_i   (sync_w),
    .rd_clr_i (rd_req_i),
    .change_o (change_w),
    .flags_o  (flags_w)
  );

  cos_irq_drive #(.WIDTH(WIDTH)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .flags_i   (flags_w),
    .mask_wr_i (mask_wr_i),
    .mask_i    (mask_i),
    .mask_o    (mask_w),
    .irq_oe_o  (oe_w)
  );

  // Read port: capture the flags present at the read edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_req_i;
      if (rd_req_i) rd_data_q <= flags_w;
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
  // Open-drain: the pad only ever pulls low; the pull-up gives the high level.
  assign irq_oe_o   = oe_w;
  assign irq_n_o    = ~oe_w;

  AST_EDGE_CAPTURED: assert property (@(posedge clk) disable iff (rst)
    (change_w != '0) |=> ((flags_w & $past(change_w)) == $past(change_w))); // R3
  AST_PENDING_PULLS_LOW: assert property (@(posedge clk) disable iff (rst)
    ((flags_w & mask_w) != '0) |=> !irq_n_o);                      // R2
  AST_NOTHING_PENDING_RELEASES: assert property (@(posedge clk) disable iff (rst)
    ((flags_w & mask_w) == '0) |=> irq_n_o);                       // R4
  AST_RD_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(rd_req_i));                               // R6
  AST_OPEN_DRAIN_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_n_o != irq_oe_o);                                          // R8
endmodule

// File: tb/cos_irq_top_bench.sv
`timescale 1ns/1ps
module cos_irq_top_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] stat = '0;
  logic         mask_wr = 1'b0;
  logic [W-1:0] mask = '0;
  logic         rd_req = 1'b0;
  logic [W-1:0] rd_data;
  logic         rd_valid;
  logic         irq_oe;
  logic         irq_n;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cos_irq_top #(.WIDTH(W), .SYNC_STAGES(2)) u_cos_irq_top (
    .clk        (clk),
    .rst        (rst),
    .stat_i     (stat),
    .mask_wr_i  (mask_wr),
    .mask_i     (mask),
    .rd_req_i   (rd_req),
    .rd_data_o  (rd_data),
    .rd_valid_o (rd_valid),
    .irq_oe_o   (irq_oe),
    .irq_n_o    (irq_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_line(input string req, input logic exp_n);
    check(req, {31'd0, irq_n}, {31'd0, exp_n});
    check("R8", {31'd0, irq_oe}, {31'd0, ~exp_n});
  endtask

  task automatic do_reset(input logic [W-1:0] level);
    rst = 1'b1; stat = level; mask_wr = 1'b0; rd_req = 1'b0;
    tick(3);
    rst = 1'b0;
  endtask

  task automatic write_mask(input logic [W-1:0] m);
    mask = m; mask_wr = 1'b1;
    tick(1);
    mask_wr = 1'b0;
  endtask

  task automatic do_read(input string req, input logic [W-1:0] exp);
    rd_req = 1'b1;
    tick(1);
    rd_req = 1'b0;
    check(req, {31'd0, rd_valid}, 32'd1);
    check(req, {24'd0, rd_data}, {24'd0, exp});
    tick(1);
    check("R6", {31'd0, rd_valid}, 32'd0);
  endtask

  task automatic t_reset;
    do_reset(8'hA5);
    check("R1", {31'd0, rd_valid}, 32'd0);
    check_line("R1", 1'b1);
    tick(6);
    write_mask(8'hFF);
    tick(2);
    check_line("R9", 1'b1);
    do_read("R9", 8'h00);
  endtask

  task automatic t_rise;
    stat = stat | 8'h02;
    tick(3);
    check_line("R2", 1'b1);
    tick(1);
    check_line("R2", 1'b0);
    rd_req = 1'b1;
    tick(1);
    rd_req = 1'b0;
    check("R6", {31'd0, rd_valid}, 32'd1);
    check("R6", {24'd0, rd_data}, 32'h02);
    check_line("R6", 1'b0);
    tick(1);
    check_line("R6", 1'b1);
  endtask

  task automatic t_fall;
    stat = stat & ~8'h01;
    tick(3);
    check_line("R3", 1'b1);
    tick(1);
    check_line("R3", 1'b0);
    do_read("R3", 8'h01);
    check_line("R3", 1'b1);
  endtask

  task automatic t_multi;
    stat = stat ^ 8'h5A;
    tick(4);
    check_line("R2", 1'b0);
    do_read("R2", 8'h5A);
  endtask

  task automatic t_masked;
    write_mask(8'h0F);
    stat = stat ^ 8'h80;
    tick(6);
    check_line("R4", 1'b1);
    do_read("R4", 8'h80);
  endtask

  task automatic t_late_enable;
    stat = stat ^ 8'h40;
    tick(6);
    check_line("R5", 1'b1);
    write_mask(8'h4F);
    check_line("R5", 1'b1);
    tick(1);
    check_line("R5", 1'b0);
    do_read("R5", 8'h40);
    check_line("R5", 1'b1);
  endtask

  task automatic t_collide;
    write_mask(8'hFF);
    stat = stat ^ 8'h10;
    tick(2);
    rd_req = 1'b1;
    tick(1);
    rd_req = 1'b0;
    check("R7", {24'd0, rd_data}, 32'h00);
    tick(1);
    check_line("R7", 1'b0);
    do_read("R7", 8'h10);
  endtask

  task automatic t_sticky;
    stat = stat ^ 8'h0C;
    tick(5);
    stat = stat ^ 8'h04;
    tick(6);
    check_line("R10", 1'b0);
    do_read("R10", 8'h0C);
    tick(1);
    check_line("R10", 1'b1);
  endtask

  initial begin
    t_reset;
    t_rise;
    t_fall;
    t_multi;
    t_masked;
    t_late_enable;
    t_collide;
    t_sticky;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule